// File: doc/BRIEF.md
# Serial Transmitter with Pin Override

This block turns bytes into asynchronous serial frames on one output pin. A frame starts with a low start bit, then sends the data bits least significant first, then an optional parity bit, then a single high stop bit. Every bit lasts a fixed number of pulses of an oversampling tick, sixteen by default. A preceding FIFO offers bytes with a valid/ready handshake. The block takes a new byte only when no frame is in progress.

A transmit enable decides who owns the pin. When the enable is high, the shift logic drives the pin and the output enable is forced on. When the enable is low, two software bits set the pin: one gives the level and one gives the output enable. Software can therefore hold the line at mark, driven high, before transmission starts. It can also force the line low to send a break. Lowering the enable hands the pin to the override bits in the same cycle and returns the sequencer to idle, even in the middle of a frame. Once the enable is raised again, the line idles high and no part of the aborted frame is sent.

Top module: `serial_tx_pinctl`

## Requirements
- R1: Out of reset with the enable high, the block is idle: `ready_o`=1 and `txd_o`=1, and no frame is pending.
- R2: While `tx_en_i`=0, `txd_o` equals `ovr_level_i` and `txd_oe_o` equals `ovr_oe_i` in the same cycle, and `ready_o`=0. This also holds during reset.
- R3: While the enable is high and no frame is running, `txd_o`=1, `txd_oe_o`=1 and `ready_o`=1. The override bits have no effect.
- R4: A frame is bit 0 = start (0), bits 1..DATA_W = data LSB first, then a parity bit if enabled (1 = even, 2 = odd), then a stop bit (1). With the default configuration a frame has 10 bits and no parity.
- R5: Each bit lasts exactly OVS ticks. `txd_o` changes only on the tick that closes a bit, so the line holds still while no tick arrives.
- R6: A byte is taken only at an edge where `valid_i` and `ready_o` are both 1. `ready_o` stays 0 from that edge until the frame ends. Bytes offered during a frame have no effect on the frame.
- R7: `ready_o` rises right after the edge of the last tick of the stop bit, so the next frame can follow back-to-back.
- R8: Clearing the enable in the middle of a frame passes the pin to the override bits at once (level 0 with output enable 1 gives a break of `txd_o`=0). After the enable is raised again, the line idles high with `ready_o`=1 and nothing of the old frame remains.
- R9: A byte offered in the same cycle that the enable is low is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Oversampling tick, one pulse per sixteenth of a bit |
| tx_en_i | input | 1 | Transmit enable; low aborts and hands the pin to the override bits |
| ovr_level_i | input | 1 | Pin level while the enable is low |
| ovr_oe_i | input | 1 | Pin output enable while the enable is low |
| data_i | input | DATA_W | Byte offered by the FIFO |
| valid_i | input | 1 | `data_i` is valid |
| ready_o | output | 1 | Block can take a byte |
| txd_o | output | 1 | Serial data to the pin |
| txd_oe_o | output | 1 | Pin output enable |

## Verification
The hardest conditions to reach are an abort at a chosen bit of a running frame and an offer that lands in the very cycle the enable drops. Both depend on where the sequencer is inside the tick stream, and that position is not visible at the ports. The bench keeps its own count of the ticks delivered since the accepting edge. With that count it lowers the enable at a known tick offset inside a chosen bit. It also stops the tick generator while a bit is in progress to show that the line holds. A sweep over all byte values, with ticks arriving at several rates, checks every bit position at both ends of its window.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } stx_state_e;

  localparam int unsigned PAR_NONE = 0;
  localparam int unsigned PAR_EVEN = 1;
  localparam int unsigned PAR_ODD  = 2;
endpackage

// File: rtl/stx_baud.sv
// Counts oversampling ticks inside one bit and flags the tick that closes it.
module stx_baud #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic bit_end_o
);
  localparam int unsigned CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign bit_end_o = !clr_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/stx_frame.sv
// Frame sequencer: builds the frame word and shifts it out LSB first.
module stx_frame
  import stx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PARITY = PAR_NONE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit_end_i,
  output logic              idle_o,
  output logic              serial_o
);
  localparam int unsigned PAR_W   = (PARITY != PAR_NONE) ? 1 : 0;
  localparam int unsigned FRAME_W = DATA_W + PAR_W + 2;
  localparam int unsigned LW      = $clog2(FRAME_W + 1);

  stx_state_e         state_q, state_d;
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [LW-1:0]      left_q, left_d;
  logic [FRAME_W-1:0] frame_word;

  generate
    if (PAR_W != 0) begin : g_par
      logic par_bit;
      assign par_bit    = (^data_i) ^ (PARITY == PAR_ODD);
      assign frame_word = {1'b1, par_bit, data_i, 1'b0};
    end else begin : g_nopar
      assign frame_word = {1'b1, data_i, 1'b0};
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    sreg_d  = sreg_q;
    left_d  = left_q;
    if (!en_i) begin
      state_d = ST_IDLE;
      sreg_d  = '1;
      left_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (load_i) begin
            state_d = ST_SEND;
            sreg_d  = frame_word;
            left_d  = LW'(FRAME_W);
          end
        end
        ST_SEND: begin
          if (bit_end_i) begin
            sreg_d = {1'b1, sreg_q[FRAME_W-1:1]};
            left_d = left_q - 1'b1;
            if (left_q == LW'(1)) begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sreg_q  <= '1;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      left_q  <= left_d;
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign serial_o = sreg_q[0];
endmodule

// File: rtl/stx_pinmux.sv
// Selects who owns the pin: shift logic when enabled, override bits otherwise.
module stx_pinmux (
  input  logic en_i,
  input  logic serial_i,
  input  logic ovr_level_i,
  input  logic ovr_oe_i,
  output logic txd_o,
  output logic txd_oe_o
);
  always_comb begin
    if (en_i) begin
      txd_o    = serial_i;
      txd_oe_o = 1'b1;
    end else begin
      txd_o    = ovr_level_i;
      txd_oe_o = ovr_oe_i;
    end
  end
endmodule

// File: rtl/serial_tx_pinctl.sv
module serial_tx_pinctl
  import stx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16,
  parameter int unsigned PARITY = PAR_NONE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              tx_en_i,
  input  logic              ovr_level_i,
  input  logic              ovr_oe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              txd_oe_o
);
  logic idle;
  logic load;
  logic bit_end;
  logic serial;
  logic baud_clr;

  assign ready_o  = tx_en_i && idle;
  assign load     = valid_i && ready_o;
  assign baud_clr = !tx_en_i || load;

  stx_baud #(
    .OVS (OVS)
  ) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (baud_clr),
    .tick_i    (tick_i),
    .bit_end_o (bit_end)
  );

  stx_frame #(
    .DATA_W (DATA_W),
    .PARITY (PARITY)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (tx_en_i),
    .load_i    (load),
    .data_i    (data_i),
    .bit_end_i (bit_end),
    .idle_o    (idle),
    .serial_o  (serial)
  );

  stx_pinmux u_pinmux (
    .en_i        (tx_en_i),
    .serial_i    (serial),
    .ovr_level_i (ovr_level_i),
    .ovr_oe_i    (ovr_oe_i),
    .txd_o       (txd_o),
    .txd_oe_o    (txd_oe_o)
  );
endmodule

// File: rtl/stx_checker.sv
module stx_checker (
  input logic clk,
  input logic rst_n,
  input logic tick_i,
  input logic tx_en_i,
  input logic ovr_level_i,
  input logic ovr_oe_i,
  input logic valid_i,
  input logic ready_o,
  input logic txd_o,
  input logic txd_oe_o
);
  // R2
  ovr_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |-> (txd_o == ovr_level_i) && (txd_oe_o == ovr_oe_i));

  // R9
  disabled_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |-> !ready_o);

  // R3
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> txd_o && txd_oe_o);

  // R4
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> (!txd_o || !tx_en_i));

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ready_o) |=> !ready_o);

  // R8
  reenable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_i && !$past(tx_en_i)) |-> ready_o && txd_o);

  // R5
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_i && $past(tx_en_i) && !$past(tick_i) && !$past(valid_i && ready_o))
      |-> $stable(txd_o));
endmodule

bind serial_tx_pinctl stx_checker u_stx_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .tx_en_i     (tx_en_i),
  .ovr_level_i (ovr_level_i),
  .ovr_oe_i    (ovr_oe_i),
  .valid_i     (valid_i),
  .ready_o     (ready_o),
  .txd_o       (txd_o),
  .txd_oe_o    (txd_oe_o)
);

// File: tb/test_serial_tx_pinctl.sv
`timescale 1ns/1ps
module test_serial_tx_pinctl;
  localparam int NB  = 10;
  localparam int OVS = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i = 1'b0;
  logic       tx_en_i, ovr_level_i, ovr_oe_i, valid_i;
  logic [7:0] data_i;
  logic       ready_o, txd_o, txd_oe_o;

  int checks = 0;
  int fails  = 0;
  int tick_total = 0;
  int tick_per = 1;
  int tphase = 0;
  bit tick_run = 1'b1;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_tx_pinctl i_serial_tx_pinctl (
    .clk (clk), .rst_n (rst_n), .tick_i (tick_i), .tx_en_i (tx_en_i),
    .ovr_level_i (ovr_level_i), .ovr_oe_i (ovr_oe_i), .data_i (data_i),
    .valid_i (valid_i), .ready_o (ready_o), .txd_o (txd_o), .txd_oe_o (txd_oe_o)
  );

  always @(negedge clk) begin
    if (tick_run) begin
      tick_i <= (tphase == 0);
      tphase <= (tphase + 1 >= tick_per) ? 0 : tphase + 1;
    end else begin
      tick_i <= 1'b0;
    end
  end

  always @(posedge clk) begin
    if (tick_i) tick_total <= tick_total + 1;
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected <190000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic fbit(input logic [7:0] b, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    return 1'b1;
  endfunction

  task automatic wait_ticks(input int base, input int t);
    while (tick_total - base < t) step();
  endtask

  // Sends one frame and checks each bit at both ends of its tick window.
  task automatic send_frame(input logic [7:0] b, input bit busy_offer, input int pause_bit);
    int base;
    logic v;
    int t0;
    step();
    valid_i = 1'b1;
    data_i  = b;
    #1;
    while (!ready_o) step();
    @(posedge clk);
    step();
    base = tick_total;
    if (busy_offer) data_i = ~b;
    else valid_i = 1'b0;
    for (int k = 0; k < NB; k++) begin
      wait_ticks(base, OVS * k);
      chk("R4 bit start", txd_o, fbit(b, k));
      chk("R6 busy", ready_o, 1'b0);
      if (k == NB - 1) valid_i = 1'b0;
      if (k == pause_bit) begin
        tick_run = 1'b0;
        step();
        step();
        v  = txd_o;
        t0 = tick_total;
        for (int i = 0; i < 30; i++) begin
          step();
          chk("R5 hold without tick", txd_o, v);
          checks++;
          if (tick_total != t0) begin
            fails++;
            $display("FAIL R5 ticks: actual=%0d expected=%0d", tick_total, t0);
          end
        end
        tick_run = 1'b1;
      end
      wait_ticks(base, OVS * k + OVS - 1);
      chk("R5 bit end", txd_o, fbit(b, k));
    end
    wait_ticks(base, OVS * NB);
    chk("R7 ready after stop", ready_o, 1'b1);
    chk("R7 idle mark", txd_o, 1'b1);
  endtask

  initial begin
    int base;
    logic [7:0] b;
    rst_n = 1'b0; tx_en_i = 1'b0; ovr_level_i = 1'b1; ovr_oe_i = 1'b1;
    valid_i = 1'b0; data_i = 8'h00;
    repeat (3) step();
    chk("R2 reset level", txd_o, 1'b1);
    chk("R2 reset oe", txd_oe_o, 1'b1);
    chk("R2 reset ready", ready_o, 1'b0);
    rst_n = 1'b1;
    valid_i = 1'b1;
    for (int m = 0; m < 4; m++) begin
      ovr_level_i = m[0];
      ovr_oe_i    = m[1];
      #1;
      chk("R2 level same cycle", txd_o, m[0]);
      chk("R2 oe same cycle", txd_oe_o, m[1]);
      step();
      chk("R2 ready low", ready_o, 1'b0);
    end
    valid_i = 1'b0;
    ovr_level_i = 1'b1; ovr_oe_i = 1'b1;
    step();
    tx_en_i = 1'b1;
    #1;
    chk("R1 ready", ready_o, 1'b1);
    chk("R1 mark", txd_o, 1'b1);
    ovr_level_i = 1'b0; ovr_oe_i = 1'b0;
    repeat (3) step();
    chk("R3 level ignores override", txd_o, 1'b1);
    chk("R3 oe forced", txd_oe_o, 1'b1);
    chk("R3 ready", ready_o, 1'b1);

    // R4 R6 R7: every byte value, one tick per cycle
    for (int i = 0; i < 256; i++) send_frame(8'(i), i[0], -1);

    // R5: slower ticks with a stall inside a chosen bit
    tick_per = 3;
    for (int i = 0; i < 10; i++) send_frame(8'(8'h3C + 37 * i), 1'b1, i);
    tick_per = 1;

    // R8: abort in the middle of chosen bits, sending a break
    for (int a = 0; a < 3; a++) begin
      step();
      valid_i = 1'b1;
      data_i  = 8'h5A;
      #1;
      while (!ready_o) step();
      @(posedge clk);
      step();
      base = tick_total;
      valid_i = 1'b0;
      wait_ticks(base, OVS * (a * 4 + 1) + 5);
      ovr_level_i = 1'b0; ovr_oe_i = 1'b1; tx_en_i = 1'b0;
      #1;
      chk("R8 break at once", txd_o, 1'b0);
      chk("R8 break oe", txd_oe_o, 1'b1);
      for (int i = 0; i < 20; i++) begin
        step();
        chk("R8 break held", txd_o, 1'b0);
      end
      ovr_level_i = 1'b1;
      tx_en_i = 1'b1;
      #1;
      chk("R8 idle after re-enable", txd_o, 1'b1);
      chk("R8 ready after re-enable", ready_o, 1'b1);
      for (int i = 0; i < 40; i++) begin
        step();
        chk("R8 no residue", txd_o, 1'b1);
      end
    end

    // R9: offer in the cycle the enable is low
    step();
    tx_en_i = 1'b0;
    valid_i = 1'b1;
    data_i  = 8'h00;
    step();
    valid_i = 1'b0;
    tx_en_i = 1'b1;
    #1;
    for (int i = 0; i < 40; i++) begin
      chk("R9 not accepted line", txd_o, 1'b1);
      chk("R9 not accepted ready", ready_o, 1'b1);
      step();
    end
    b = 8'hC3;
    send_frame(b, 1'b0, -1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule